// File: doc/BRIEF.md
# Stop-Mode On-Demand Clock Gate Controller

This block manages clock and oscillator enables around a deep low-power stop state. In run mode it holds every core clock, the PLL, the external oscillator and the internal 16 MHz oscillator on. It also opens every peripheral clock gate. A wait instruction with the deep-sleep bit set moves it into stop. In stop, the core clocks and all oscillator enables drop, while the brown-out monitor enable stays high. Memory, registers and pins keep their state, so entering stop drives no reset and changes no other output.

While stopped, the wakeup-capable serial peripherals can each ask for a clock so they can receive a frame. There are four I2C instances, five UARTs and one low-power UART. A request turns the internal oscillator on. Once the oscillator reports ready, that clock is passed only to the peripherals that asked for it. When a peripheral finishes a frame that is not a wakeup frame, its gate closes and its request is dropped. The oscillator turns off once no request is outstanding, and the system stays stopped. A wakeup frame raises a one-cycle wakeup pulse and returns the block to run mode, which restores every enable.

Top module: `stopclk_gate_ctrl`

## Requirements
- R1: After reset the block is in run mode. All of `core_clk_en` and `per_clk_en` are high, `pll_en`, `hse_en`, `hsi_en` and `bor_en` are high, and `wakeup` is low.
- R2: Stop is entered only when `wait_req` and `deep_sleep` are both high in the same cycle. The outputs change in the following cycle. Either signal alone leaves run mode in place.
- R3: In stop with no outstanding request, `core_clk_en` and `per_clk_en` are all zero, and `pll_en`, `hse_en` and `hsi_en` are low.
- R4: A request seen in stop raises `hsi_en` in the next cycle. `hsi_en` stays high until every outstanding request has completed.
- R5: In stop, a peripheral gate opens only at a clock edge where `hsi_rdy` is high and `hsi_en` was already high. The gate never opens before the oscillator is ready.
- R6: In stop, only the bits of `per_clk_en` that belong to requesting peripherals are set. The bit order is I2C instances in bits 0 to 3, UARTs in bits 4 to 8, and the low-power UART in bit 9.
- R7: Concurrent requests each get their own gate. A request arriving while the oscillator is on and ready gets its gate in the next cycle.
- R8: A `per_frame_done` pulse on an open gate with `per_frame_wake` low closes that gate and drops that request, and the block stays in stop. When the last request completes, `hsi_en` falls in the next cycle.
- R9: `bor_en` is high in every cycle, in run and in stop.
- R10: A `per_frame_done` pulse with `per_frame_wake` high on an open gate makes `wakeup` high for exactly one cycle. In that same cycle, all run-mode enables are restored.
- R11: Frame-done or wake flags from a peripheral whose gate is closed are ignored. Requests in run mode are ignored. A wait with deep sleep while already stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | Wait instruction executed |
| deep_sleep | input | 1 | Deep-sleep control bit |
| per_req | input | NP | Per-peripheral clock request |
| per_frame_done | input | NP | Per-peripheral frame complete |
| per_frame_wake | input | NP | Completed frame is a wakeup frame |
| hsi_rdy | input | 1 | Internal oscillator ready |
| hsi_en | output | 1 | Internal 16 MHz oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| bor_en | output | 1 | Brown-out monitor enable |
| core_clk_en | output | N_CORE_CLK | Core-domain clock gate enables |
| per_clk_en | output | NP | Peripheral clock gate enables |
| wakeup | output | 1 | One-cycle wakeup pulse |

## Verification
A request slot whose pending bit is stuck shows up within one cycle. It keeps `hsi_en` high after the last non-wakeup frame, or it leaves a foreign bit set in `per_clk_en`. A gate register that ignores ready opens a bit in the same cycle as the request, before `hsi_rdy`, which is visible one edge too early. A mode register that takes the wrong branch shows up at the next edge in `pll_en` and `core_clk_en`. A missing pulse clear shows up as a `wakeup` that stays high for a second cycle.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [0:0] {
        PM_RUN  = 1'b0,
        PM_STOP = 1'b1
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
        logic      wake;
    } fsm_regs_t;

    typedef struct packed {
        logic pend;
        logic gate;
    } slot_regs_t;

endpackage

// File: rtl/stopclk_slot.sv
module stopclk_slot
    import stopclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stopped,
    input  logic wake_all,
    input  logic osc_on,
    input  logic osc_ready,
    input  logic req,
    input  logic frame_done,
    input  logic frame_wake,
    output logic gate,
    output logic pending,
    output logic wake_hit
);

    slot_regs_t s_d, s_q;
    logic       hit;
    logic       release_req;

    always_comb begin
        hit         = frame_done & s_q.gate & stopped;
        wake_hit    = hit & frame_wake;
        release_req = hit & ~frame_wake;
        s_d         = s_q;
        if (!stopped || wake_all) begin
            s_d = '0;
        end else begin
            s_d.pend = (s_q.pend & ~release_req) | req;
            s_d.gate = s_d.pend & osc_on & osc_ready;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gate    = s_q.gate;
    assign pending = s_q.pend;

endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_req,
    input  logic deep_sleep,
    input  logic any_wake,
    output logic stopped,
    output logic wake_pulse
);

    fsm_regs_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.wake = 1'b0;
        unique case (f_q.st)
            PM_RUN: begin
                if (wait_req && deep_sleep) f_d.st = PM_STOP;
            end
            PM_STOP: begin
                if (any_wake) begin
                    f_d.st   = PM_RUN;
                    f_d.wake = 1'b1;
                end
            end
            default: f_d.st = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: PM_RUN, wake: 1'b0};
        else        f_q <= f_d;
    end

    assign stopped    = (f_q.st == PM_STOP);
    assign wake_pulse = f_q.wake;

endmodule

// File: rtl/stopclk_gate_ctrl.sv
module stopclk_gate_ctrl
    import stopclk_pkg::*;
#(
    parameter  int N_I2C      = 4,
    parameter  int N_UART     = 5,
    parameter  int N_LPUART   = 1,
    parameter  int N_CORE_CLK = 4,
    localparam int NP         = N_I2C + N_UART + N_LPUART
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wait_req,
    input  logic                  deep_sleep,
    input  logic [NP-1:0]         per_req,
    input  logic [NP-1:0]         per_frame_done,
    input  logic [NP-1:0]         per_frame_wake,
    input  logic                  hsi_rdy,
    output logic                  hsi_en,
    output logic                  hse_en,
    output logic                  pll_en,
    output logic                  bor_en,
    output logic [N_CORE_CLK-1:0] core_clk_en,
    output logic [NP-1:0]         per_clk_en,
    output logic                  wakeup
);

    logic          stopped;
    logic          wake_pulse;
    logic          any_wake;
    logic          any_pend;
    logic [NP-1:0] slot_gate;
    logic [NP-1:0] slot_pend;
    logic [NP-1:0] slot_wake;

    assign any_wake = |slot_wake;
    assign any_pend = |slot_pend;

    stopclk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_req   (wait_req),
        .deep_sleep (deep_sleep),
        .any_wake   (any_wake),
        .stopped    (stopped),
        .wake_pulse (wake_pulse)
    );

    for (genvar i = 0; i < NP; i++) begin : g_slot
        stopclk_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .stopped    (stopped),
            .wake_all   (any_wake),
            .osc_on     (any_pend),
            .osc_ready  (hsi_rdy),
            .req        (per_req[i]),
            .frame_done (per_frame_done[i]),
            .frame_wake (per_frame_wake[i]),
            .gate       (slot_gate[i]),
            .pending    (slot_pend[i]),
            .wake_hit   (slot_wake[i])
        );
    end

    always_comb begin
        core_clk_en = stopped ? '0 : '1;
        per_clk_en  = stopped ? slot_gate : '1;
        pll_en      = ~stopped;
        hse_en      = ~stopped;
        hsi_en      = ~stopped | any_pend;
        bor_en      = 1'b1;
        wakeup      = wake_pulse;
    end

endmodule

// File: rtl/stopclk_gate_chk.sv
module stopclk_gate_chk #(
    parameter int NP         = 10,
    parameter int N_CORE_CLK = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wait_req,
    input logic                  deep_sleep,
    input logic                  hsi_rdy,
    input logic                  hsi_en,
    input logic                  pll_en,
    input logic [N_CORE_CLK-1:0] core_clk_en,
    input logic [NP-1:0]         per_clk_en,
    input logic                  wakeup
);

    // R2
    entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> $past(wait_req && deep_sleep));

    // R5
    gate_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_en && (per_clk_en != '0)) |-> $past(hsi_rdy));

    // R5
    gate_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_en && (per_clk_en != '0)) |-> hsi_en);

    // R8
    osc_off_gates_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_en && !hsi_en) |-> (per_clk_en == '0));

    // R10
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |=> !wakeup);

    // R10
    wake_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> (pll_en && (&core_clk_en) && (&per_clk_en)));

endmodule

bind stopclk_gate_ctrl stopclk_gate_chk #(.NP(NP), .N_CORE_CLK(N_CORE_CLK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_req    (wait_req),
    .deep_sleep  (deep_sleep),
    .hsi_rdy     (hsi_rdy),
    .hsi_en      (hsi_en),
    .pll_en      (pll_en),
    .core_clk_en (core_clk_en),
    .per_clk_en  (per_clk_en),
    .wakeup      (wakeup)
);

// File: tb/stopclk_gate_ctrl_bench.sv
module stopclk_gate_ctrl_bench;

    localparam int NP = 10;
    localparam int NC = 4;

    typedef struct {
        logic [NC-1:0] core;
        logic          pll;
        logic          hse;
        logic          hsi;
        logic [NP-1:0] per;
        logic          wake;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wait_req = 1'b0;
    logic          deep_sleep = 1'b0;
    logic [NP-1:0] per_req = '0;
    logic [NP-1:0] per_frame_done = '0;
    logic [NP-1:0] per_frame_wake = '0;
    logic          hsi_rdy = 1'b0;
    logic          hsi_en, hse_en, pll_en, bor_en, wakeup;
    logic [NC-1:0] core_clk_en;
    logic [NP-1:0] per_clk_en;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cycles   = 0;
    exp_t exp_q[$];
    exp_t cur;

    always #4 clk = ~clk;

    stopclk_gate_ctrl u_stopclk_gate_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wait_req       (wait_req),
        .deep_sleep     (deep_sleep),
        .per_req        (per_req),
        .per_frame_done (per_frame_done),
        .per_frame_wake (per_frame_wake),
        .hsi_rdy        (hsi_rdy),
        .hsi_en         (hsi_en),
        .hse_en         (hse_en),
        .pll_en         (pll_en),
        .bor_en         (bor_en),
        .core_clk_en    (core_clk_en),
        .per_clk_en     (per_clk_en),
        .wakeup         (wakeup)
    );

    task automatic step(input logic w, input logic d, input logic [NP-1:0] rq,
                        input logic [NP-1:0] dn, input logic [NP-1:0] wf, input logic rdy,
                        input logic run, input logic hsi, input logic [NP-1:0] per,
                        input logic wk, input string tag);
        exp_t e;
        @(negedge clk);
        wait_req = w; deep_sleep = d; per_req = rq;
        per_frame_done = dn; per_frame_wake = wf; hsi_rdy = rdy;
        e.core = run ? '1 : '0;
        e.pll  = run;
        e.hse  = run;
        e.hsi  = hsi;
        e.per  = per;
        e.wake = wk;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            n_checks++;
            if (core_clk_en !== cur.core || pll_en !== cur.pll || hse_en !== cur.hse ||
                hsi_en !== cur.hsi || per_clk_en !== cur.per || wakeup !== cur.wake ||
                bor_en !== 1'b1) begin
                n_fails++;
                $display("FAIL %s: got core=%h pll=%b hse=%b hsi=%b per=%h wake=%b bor=%b exp core=%h pll=%b hse=%b hsi=%b per=%h wake=%b bor=1",
                         cur.tag, core_clk_en, pll_en, hse_en, hsi_en, per_clk_en, wakeup, bor_en,
                         cur.core, cur.pll, cur.hse, cur.hsi, cur.per, cur.wake);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_fails++;
                $display("FAIL watchdog: got hung run exp completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    localparam logic [NP-1:0] Z   = '0;
    localparam logic [NP-1:0] ALL = '1;
    localparam logic [NP-1:0] P0  = 10'h001;
    localparam logic [NP-1:0] P2  = 10'h004;
    localparam logic [NP-1:0] P3  = 10'h008;
    localparam logic [NP-1:0] P7  = 10'h080;
    localparam logic [NP-1:0] P9  = 10'h200;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R9 bor high
        step(0, 0, Z,  Z,  Z,  0, 1, 1, ALL, 0, "R1 reset run state");
        // R2 wait alone, deep sleep alone
        step(1, 0, Z,  Z,  Z,  0, 1, 1, ALL, 0, "R2 wait without deep sleep");
        step(0, 1, Z,  Z,  Z,  0, 1, 1, ALL, 0, "R2 deep sleep without wait");
        // R11 request in run ignored
        step(0, 0, P0, Z,  Z,  0, 1, 1, ALL, 0, "R11 run request ignored");
        // R2 R3 entry
        step(1, 1, Z,  Z,  Z,  0, 0, 0, Z,   0, "R3 stop entry clocks off");
        step(0, 0, Z,  Z,  Z,  0, 0, 0, Z,   0, "R9 stop idle, run request not kept");
        // R11 wait again while stopped, stray done/wake
        step(1, 1, Z,  Z,  Z,  0, 0, 0, Z,   0, "R11 wait in stop ignored");
        step(0, 0, Z,  P2, P2, 0, 0, 0, Z,   0, "R11 done without gate ignored");
        // R4 R5 request before ready
        step(0, 0, P3, Z,  Z,  0, 0, 1, Z,   0, "R4 request raises oscillator");
        step(0, 0, Z,  Z,  Z,  0, 0, 1, Z,   0, "R5 gate held until ready");
        step(0, 0, Z,  Z,  Z,  1, 0, 1, P3,  0, "R6 only requester gated");
        step(0, 0, Z,  Z,  P3, 1, 0, 1, P3,  0, "R11 wake flag without done ignored");
        // R7 concurrent
        step(0, 0, P7, Z,  Z,  1, 0, 1, P3 | P7, 0, "R7 second requester gated");
        // R8 non-wake frames
        step(0, 0, Z,  P3, Z,  1, 0, 1, P7,  0, "R8 first frame done, osc kept");
        step(0, 0, Z,  P7, Z,  1, 0, 0, Z,   0, "R8 last frame done, osc off");
        // R5 request with ready already high but osc off
        step(0, 0, P9, Z,  Z,  1, 0, 1, Z,   0, "R5 ready before osc on ignored");
        step(0, 0, Z,  Z,  Z,  1, 0, 1, P9,  0, "R6 low-power uart gated");
        // R10 wakeup frame
        step(0, 0, Z,  P9, P9, 1, 1, 1, ALL, 1, "R10 wakeup frame returns to run");
        step(0, 0, Z,  Z,  Z,  0, 1, 1, ALL, 0, "R10 wakeup single cycle");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule